// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block interprets the command traffic of a small serial EEPROM with 512 bytes of storage. A serial front end deserialises the bus and hands over one whole byte per `rxValid` strobe. For every byte slot, the block answers with the byte to shift out and a drive enable. The first byte of a selection is the instruction. Depending on its value, the engine either takes an address byte and then streams read data from a byte-wide memory model, or streams the status byte, or passes page-write bytes to a separate write controller, or changes the write-enable latch or the protection bits at deselect.

The engine owns the write-enable latch and the two block-protection bits. The external write controller reports its internal programming cycle through `wrBusy`. That flag is shown in the status byte and locks out every instruction except the status read. Page loads leave the block one byte at a time on `wrLoad`, and a single `wrCommit` pulse at a clean deselect starts the internal write.

Top module: `eep_cmd_engine`

## Requirements
- R1: Instruction codes: 0x06 sets the write latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0000_A011 reads and 0000_A010 writes memory. Bit 3 (A) of the read/write code becomes address bit 8, and the next byte supplies address bits 7..0.
- R2: Any other instruction byte is ignored. `txEn` stays 0 and nothing is loaded or committed for the rest of that selection.
- R3: The status byte is {1111, BP1, BP0, WEL, busy}, with busy equal to `wrBusy`. After 0x05 it is driven in every following byte slot until deselect, and it can be read while busy.
- R4: The write latch changes only when chip select drops with `byteAligned`=1 after exactly one byte (the instruction). Extra bytes or a partial byte leave it unchanged.
- R5: A read drives memory data starting with the first slot after the address byte. The address increments after each slot and wraps from 0x1FF to 0x000.
- R6: While `wrBusy`=1, every instruction other than 0x05 is ignored, as in R2.
- R7: After reset WEL=0, BP=00 and `txEn`=0.
- R8: A memory write needs WEL=1. Each data byte gives one `wrLoad` pulse. The low 4 address bits increment and wrap within the 16-byte page, and the upper bits stay fixed. `wrCommit` pulses once at an aligned deselect after at least one data byte, and WEL then reads 0.
- R9: A status write needs WEL=1. Only data bits 3..2 reach BP1..BP0. The write commits with `wrCommit` and `wrStatus` both high, and WEL then reads 0.
- R10: A deselect before the address byte, before any data byte, or at a partial byte gives no commit and leaves WEL and BP unchanged.
- R11: The protected region for a write depends on BP: BP=01 protects 0x180-0x1FF, BP=10 protects 0x100-0x1FF, and BP=11 protects everything. A memory write that starts in a protected region produces no load and no commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csActive | input | 1 | Chip selected (1 = selected) |
| byteAligned | input | 1 | Front end holds a whole number of bytes |
| rxValid | input | 1 | One received byte is on `rxByte` |
| rxByte | input | 8 | Received byte |
| txEn | output | 1 | Drive output for the current byte slot |
| txByte | output | 8 | Byte to shift out in the current slot |
| memRdAddr | output | 9 | Memory model read address |
| memRdData | input | 8 | Memory model read data |
| wrBusy | input | 1 | Internal write cycle running |
| wrLoad | output | 1 | Page byte strobe to write controller |
| wrAddr | output | 9 | Address of the page byte |
| wrData | output | 8 | Page byte value |
| wrCommit | output | 1 | Start internal write |
| wrStatus | output | 1 | Commit is a status write |

## Verification
The in-line properties watch, on every cycle, that page loads happen only with the latch set, that a commit always leaves the latch clear, that page loads keep the page bits fixed, that the read pointer wraps at the top address, that the protection bits move only on a status commit, and that a non-status instruction arriving while busy drops the engine into its ignore state. Only the bench scenarios can show the full ordering behaviour: the exact status byte values, streamed read data across the wrap, the page roll-over order, and that aborted, misaligned or protected commands leave no trace.

// File: rtl/eep_cmd_pkg.sv
package eep_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_RDATA, ST_STAT, ST_OPDONE, ST_DEAD
  } engState_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } opKind_t;

  typedef struct packed {
    logic loadHi;    // capture address bit 8 from instruction
    logic loadAddr;  // capture low address byte
    logic incRead;   // linear increment
    logic incPage;   // in-page increment
    logic setWel;
    logic clrWel;
    logic capBp;     // hold incoming protection bits
    logic commitBp;  // apply held protection bits
  } dpStrobe_t;

  function automatic opKind_t decodeOp(input logic [7:0] b);
    casez (b)
      8'h06:       decodeOp = OP_WREN;
      8'h04:       decodeOp = OP_WRDI;
      8'h05:       decodeOp = OP_RDSR;
      8'h01:       decodeOp = OP_WRSR;
      8'b0000?011: decodeOp = OP_READ;
      8'b0000?010: decodeOp = OP_WRITE;
      default:     decodeOp = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csActive,
  input  logic       byteAligned,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       wrBusy,
  input  logic       welQ,
  input  logic       protHit,
  output dpStrobe_t  st,
  output logic       txEn,
  output logic       txStatus,
  output logic       wrLoad,
  output logic       wrCommit,
  output logic       wrStatus
);

  engState_t state, nxtState;
  opKind_t   kind, nxtKind;
  opKind_t   rxOp;
  logic      gotData, nxtGot;

  assign rxOp = decodeOp(rxByte);

  always_comb begin
    nxtState = state;
    nxtKind  = kind;
    nxtGot   = gotData;
    st       = '0;
    wrLoad   = 1'b0;
    wrCommit = 1'b0;
    wrStatus = 1'b0;
    if (!csActive) begin
      nxtState = ST_IDLE;
      nxtGot   = 1'b0;
      if (byteAligned) begin
        if (state == ST_OPDONE) begin
          if (kind == OP_WREN) st.setWel = 1'b1;
          else                 st.clrWel = 1'b1;
        end
        if (state == ST_WDATA && gotData) begin
          wrCommit    = 1'b1;
          wrStatus    = (kind == OP_WRSR);
          st.commitBp = (kind == OP_WRSR);
          st.clrWel   = 1'b1;
        end
      end
    end else if (rxValid) begin
      case (state)
        ST_IDLE: begin
          nxtKind   = rxOp;
          st.loadHi = 1'b1;
          if (rxOp == OP_NONE || (wrBusy && rxOp != OP_RDSR)) nxtState = ST_DEAD;
          else begin
            case (rxOp)
              OP_WREN, OP_WRDI: nxtState = ST_OPDONE;
              OP_RDSR:          nxtState = ST_STAT;
              OP_READ:          nxtState = ST_ADDR;
              OP_WRITE:         nxtState = welQ ? ST_ADDR : ST_DEAD;
              OP_WRSR:          nxtState = welQ ? ST_WDATA : ST_DEAD;
              default:          nxtState = ST_DEAD;
            endcase
          end
        end
        ST_ADDR: begin
          st.loadAddr = 1'b1;
          if (kind == OP_READ) nxtState = ST_RDATA;
          else                 nxtState = protHit ? ST_DEAD : ST_WDATA;
        end
        ST_WDATA: begin
          nxtGot = 1'b1;
          if (kind == OP_WRITE) begin
            wrLoad     = 1'b1;
            st.incPage = 1'b1;
          end else if (!gotData) begin
            st.capBp = 1'b1;
          end
        end
        ST_RDATA:  st.incRead = 1'b1;
        ST_OPDONE: nxtState = ST_DEAD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind    <= OP_NONE;
      gotData <= 1'b0;
    end else begin
      state   <= nxtState;
      kind    <= nxtKind;
      gotData <= nxtGot;
    end
  end

  assign txEn     = csActive && (state == ST_RDATA || state == ST_STAT);
  assign txStatus = (state == ST_STAT);

  AST_LOAD_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wrLoad |-> welQ); // R8
  AST_COMMIT_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    wrCommit |=> !welQ); // R8
  AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    (csActive && rxValid && state == ST_IDLE && wrBusy && rxOp != OP_RDSR)
      |=> (state == ST_DEAD)); // R6

endmodule

// File: rtl/eep_cmd_dp.sv
module eep_cmd_dp
  import eep_cmd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         st,
  input  logic [7:0]        rxByte,
  input  logic              wrBusy,
  input  logic              txStatus,
  input  logic [7:0]        memRdData,
  output logic [ADDR_W-1:0] addr,
  output logic              welQ,
  output logic              protHit,
  output logic [7:0]        txByte
);

  localparam int LOW_W = ADDR_W - 1;

  logic [1:0] bp, pendBp;
  logic [7:0] statusByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      welQ   <= 1'b0;
      bp     <= 2'b00;
      pendBp <= 2'b00;
    end else begin
      if (st.loadHi)   addr[ADDR_W-1] <= rxByte[3];
      if (st.loadAddr) addr[LOW_W-1:0] <= rxByte[LOW_W-1:0];
      if (st.incRead)  addr <= addr + 1'b1;
      if (st.incPage)  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
      if (st.setWel)   welQ <= 1'b1;
      else if (st.clrWel) welQ <= 1'b0;
      if (st.capBp)    pendBp <= rxByte[3:2];
      if (st.commitBp) bp <= pendBp;
    end
  end

  // protection judged on the start address {bit8 held, incoming low byte}
  always_comb begin
    case (bp)
      2'b01:   protHit = addr[ADDR_W-1] && rxByte[LOW_W-1];
      2'b10:   protHit = addr[ADDR_W-1];
      2'b11:   protHit = 1'b1;
      default: protHit = 1'b0;
    endcase
  end

  assign statusByte = {4'hF, bp, welQ, wrBusy};
  assign txByte     = txStatus ? statusByte : memRdData;

  AST_READ_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st.incRead && addr == '1) |=> (addr == '0)); // R5
  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    st.incPage |=> (addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]))); // R8
  AST_BP_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !st.commitBp |=> $stable(bp)); // R9

endmodule

// File: rtl/eep_cmd_engine.sv
module eep_cmd_engine
  import eep_cmd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csActive,
  input  logic              byteAligned,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              txEn,
  output logic [7:0]        txByte,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  input  logic              wrBusy,
  output logic              wrLoad,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit,
  output logic              wrStatus
);

  dpStrobe_t         strobes;
  logic              welQ, protHit, txStatus;
  logic [ADDR_W-1:0] addr;

  eep_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .csActive(csActive), .byteAligned(byteAligned),
    .rxValid(rxValid), .rxByte(rxByte), .wrBusy(wrBusy), .welQ(welQ),
    .protHit(protHit), .st(strobes), .txEn(txEn), .txStatus(txStatus),
    .wrLoad(wrLoad), .wrCommit(wrCommit), .wrStatus(wrStatus)
  );

  eep_cmd_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(strobes), .rxByte(rxByte), .wrBusy(wrBusy),
    .txStatus(txStatus), .memRdData(memRdData), .addr(addr), .welQ(welQ),
    .protHit(protHit), .txByte(txByte)
  );

  assign memRdAddr = addr;
  assign wrAddr    = addr;
  assign wrData    = rxByte;

endmodule

// File: tb/eep_cmd_engine_bench.sv
module eep_cmd_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csActive = 1'b0, byteAligned = 1'b1, rxValid = 1'b0, wrBusy = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       txEn, wrLoad, wrCommit, wrStatus;
  logic [7:0] txByte, wrData, memRdData;
  logic [8:0] memRdAddr, wrAddr;
  logic [7:0] mem [512];

  int errors = 0, checks = 0, commits = 0, statCommits = 0;
  logic [8:0]  txQ[$];
  logic [16:0] ldQ[$];

  always #5 clk = ~clk;

  assign memRdData = mem[memRdAddr];

  eep_cmd_engine u_eep_cmd_engine (
    .clk(clk), .rst_n(rst_n), .csActive(csActive), .byteAligned(byteAligned),
    .rxValid(rxValid), .rxByte(rxByte), .txEn(txEn), .txByte(txByte),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .wrBusy(wrBusy),
    .wrLoad(wrLoad), .wrAddr(wrAddr), .wrData(wrData),
    .wrCommit(wrCommit), .wrStatus(wrStatus)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each byte slot and each page load against the queues
  always @(negedge clk) begin
    if (rst_n && rxValid && csActive) begin
      logic [8:0] got, exp;
      got = {txEn, txEn ? txByte : 8'h00};
      if (txQ.size() == 0) check(1'b0, "R1 slot without expectation", {23'd0, got}, 0);
      else begin
        exp = txQ.pop_front();
        check(got == exp, "R1/R2/R3/R5/R6 tx slot", {23'd0, got}, {23'd0, exp});
      end
    end
    if (rst_n && wrLoad) begin
      if (ldQ.size() == 0) check(1'b0, "R8/R11 unexpected load", {15'd0, wrAddr, wrData}, 0);
      else begin
        logic [16:0] e;
        e = ldQ.pop_front();
        check({wrAddr, wrData} == e, "R8 load addr/data", {15'd0, wrAddr, wrData}, {15'd0, e});
      end
    end
    if (rst_n && wrCommit) begin
      commits++;
      if (wrStatus) statCommits++;
    end
  end

  task automatic sel();
    @(posedge clk); #1 csActive = 1'b1;
  endtask

  task automatic desel(input bit aligned = 1'b1);
    @(posedge clk); #1 csActive = 1'b0; byteAligned = aligned;
    @(posedge clk); #1 byteAligned = 1'b1;
    @(posedge clk);
  endtask

  task automatic sendB(input logic [7:0] b, input logic [8:0] expTx = 9'h000);
    txQ.push_back(expTx);
    @(posedge clk); #1 rxValid = 1'b1; rxByte = b;
    @(posedge clk); #1 rxValid = 1'b0;
  endtask

  task automatic cmd1(input logic [7:0] op, input bit aligned = 1'b1);
    sel(); sendB(op); desel(aligned);
  endtask

  task automatic readStatus(input logic [7:0] exp);
    sel(); sendB(8'h05); sendB(8'h00, {1'b1, exp}); sendB(8'h00, {1'b1, exp}); desel();
  endtask

  task automatic checkCommits(input int expN, input int expS, input string tag);
    check(commits == expN, tag, commits, expN);
    check(statCommits == expS, tag, statCommits, expS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(txEn == 1'b0, "R7 reset txEn", txEn, 0);
    readStatus(8'hF0);                                   // R7 WEL=0 BP=00, R3 streaming

    // R8: write without WEL does nothing
    sel(); sendB(8'h02); sendB(8'h10); sendB(8'hAA); desel();
    checkCommits(0, 0, "R8 no-WEL commit");

    // R4: set latch, then misfires that must not clear it
    cmd1(8'h06); readStatus(8'hF2);
    sel(); sendB(8'h04); sendB(8'h00); desel();          // extra byte
    cmd1(8'h04, 1'b0);                                   // partial byte
    readStatus(8'hF2);                                   // R4
    cmd1(8'h04); readStatus(8'hF0);                      // R4 proper clear
    cmd1(8'h06);

    // R8 + R1: page write at 0x11E rolls within page
    ldQ.push_back({9'h11E, 8'h11}); ldQ.push_back({9'h11F, 8'h22}); ldQ.push_back({9'h110, 8'h33});
    sel(); sendB(8'h0A); sendB(8'h1E); sendB(8'h11); sendB(8'h22); sendB(8'h33); desel();
    checkCommits(1, 0, "R8 page commit");
    readStatus(8'hF0);                                   // R8 WEL cleared

    // R10: aborted writes
    cmd1(8'h06);
    sel(); sendB(8'h02); desel();
    sel(); sendB(8'h02); sendB(8'h05); desel();
    ldQ.push_back({9'h005, 8'h77});
    sel(); sendB(8'h02); sendB(8'h05); sendB(8'h77); desel(1'b0);
    checkCommits(1, 0, "R10 abort no commit");
    readStatus(8'hF2);                                   // R10 WEL kept

    // R9: status write, only bits 3..2 land
    sel(); sendB(8'h01); sendB(8'hFF); desel();
    checkCommits(2, 1, "R9 status commit");
    readStatus(8'hFC);
    sel(); sendB(8'h01); sendB(8'h00); desel();          // no WEL
    readStatus(8'hFC);                                   // R9 unchanged

    // R11: full protection blocks, then quarter protection
    cmd1(8'h06);
    sel(); sendB(8'h02); sendB(8'h00); sendB(8'h55); desel();
    checkCommits(2, 1, "R11 full protect");
    sel(); sendB(8'h01); sendB(8'h04); desel();          // BP=01
    readStatus(8'hF4);
    cmd1(8'h06);
    sel(); sendB(8'h0A); sendB(8'h80); sendB(8'h66); desel();
    checkCommits(3, 2, "R11 quarter protect 0x180");
    ldQ.push_back({9'h17F, 8'h99});
    sel(); sendB(8'h0A); sendB(8'h7F); sendB(8'h99); desel();
    checkCommits(4, 2, "R11 unprotected 0x17F");

    // R6: busy lockout, R3 status during busy
    wrBusy = 1'b1;
    cmd1(8'h06);
    readStatus(8'hF5);                                   // R3 R6 busy=1, WEL still 0
    sel(); sendB(8'h03); sendB(8'h10); sendB(8'h00); desel();  // R6 read ignored
    wrBusy = 1'b0;

    // R5: read across top with wrap, and plain read
    sel(); sendB(8'h0B); sendB(8'hFE);
    sendB(8'h00, {1'b1, mem[9'h1FE]}); sendB(8'h00, {1'b1, mem[9'h1FF]}); sendB(8'h00, {1'b1, mem[9'h000]});
    desel();
    sel(); sendB(8'h03); sendB(8'h10);
    sendB(8'h00, {1'b1, mem[9'h010]}); sendB(8'h00, {1'b1, mem[9'h011]}); desel();

    // R2: unknown instructions
    sel(); sendB(8'hFF); sendB(8'h00); sendB(8'h00); desel();
    sel(); sendB(8'h1B); sendB(8'h00); desel();
    checkCommits(4, 2, "R2 unknown no commit");

    check(txQ.size() == 0, "R1 tx queue drained", txQ.size(), 0);
    check(ldQ.size() == 0, "R8 load queue drained", ldQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule